// File: doc/BRIEF.md
# Miss-Rate Threshold Monitor

This block watches the hit/miss outcome of every cache access and decides whether the miss rate is above a fixed ratio. It does not divide anything. It keeps a small signed score instead. Each hit takes 1 from the score, and each miss adds a heavy weight of 19. When the score is positive, misses have outrun one per nineteen hits, which is a miss rate above 5%. The score saturates at both ends of its range and never wraps.

The score is judged once per window of accepted accesses, and the score is then cleared. A high score at the end of a window asks the resizable cache to grow by one level. A score that has sunk to a low mark asks it to shrink. Either request is a single-cycle pulse. It is withheld while a resize is still under way, and also when the size level already sits at the end it would move towards. Cutting power to arrays and flushing dirty lines belong to the cache and not to this monitor.

Top module: `miss_rate_monitor`

## Requirements
- R1: After an active-low reset, above_thresh, grow_req and shrink_req are 0, the score is 0 and the window count is 0.
- R2: An accepted hit (acc_valid=1, acc_miss=0) lowers the signed 8-bit score by 1, saturating at -128.
- R3: An accepted miss (acc_valid=1, acc_miss=1) raises the score by 19, saturating at +127.
- R4: above_thresh is 1 exactly while the registered score is greater than 0. It changes in the cycle after the access that moves the score.
- R5: A decision is taken on every 256th accepted access. Cycles with acc_valid=0 neither advance the window nor change the score. After a decision the score returns to 0.
- R6: grow_req pulses for one cycle, the cycle after the window's last access, when the score including that access is greater than 0.
- R7: shrink_req pulses for one cycle, the cycle after the window's last access, when the score including that access is at or below the low mark (default -128).
- R8: When resize_busy is 1 during the window's last access, neither request is issued, and the score is still cleared.
- R9: size_level is clamped to the range 1 (minimum) to 6 (maximum) before use. A grow is issued only below the maximum, and a shrink only above the minimum, so level 7 cannot grow and level 0 cannot shrink.
- R10: grow_req and shrink_req are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | One cache access completes this cycle |
| acc_miss | input | 1 | 1 = that access missed, 0 = it hit |
| size_level | input | 3 | Current enabled size level of the cache |
| resize_busy | input | 1 | A resize is still in progress |
| above_thresh | output | 1 | Score above zero (miss rate above threshold) |
| grow_req | output | 1 | One-cycle request for a larger cache |
| shrink_req | output | 1 | One-cycle request for a smaller cache |

## Verification
Every result goes through one register. The score moves at the edge that samples an access, so above_thresh reflects that access in the very next cycle. A request pulse is likewise present for exactly the one cycle after the edge that takes in the window's final access. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. It compares above_thresh and both requests in every cycle against its own saturating score and window model. The directed sequences place the samples just before and just after each score crossing and each window boundary, and these include windows broken up by idle cycles.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

  // Weighted, saturating score update for one access.
  function automatic int score_step(input int cur, input logic miss,
                                    input int up, input int down,
                                    input int lo, input int hi);
    int t;
    t = miss ? cur + up : cur - down;
    if (t > hi) t = hi;
    if (t < lo) t = lo;
    return t;
  endfunction

  // Force a size level into the legal range.
  function automatic int level_clip(input int lvl, input int lo, input int hi);
    if (lvl > hi) return hi;
    if (lvl < lo) return lo;
    return lvl;
  endfunction

endpackage

// File: rtl/mrm_score.sv
module mrm_score #(
  parameter int CNT_W    = 8,
  parameter int MISS_INC = 19,
  parameter int HIT_DEC  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_miss,
  input  logic                    clear,
  output logic signed [CNT_W-1:0] score_q,
  output logic signed [CNT_W-1:0] score_nxt
);
  localparam int SMAX = (2 ** (CNT_W - 1)) - 1;
  localparam int SMIN = -(2 ** (CNT_W - 1));

  always_comb begin
    int t;
    t = int'(score_q);
    if (acc_valid) t = mrm_pkg::score_step(t, acc_miss, MISS_INC, HIT_DEC, SMIN, SMAX);
    score_nxt = t[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     score_q <= '0;
    else if (clear) score_q <= '0;
    else            score_q <= score_nxt;
  end
endmodule

// File: rtl/mrm_window.sv
module mrm_window #(
  parameter int WINDOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  output logic win_end
);
  localparam int WCW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WCW-1:0] LAST = WCW'(WINDOW - 1);

  logic [WCW-1:0] wcnt;

  assign win_end = acc_valid && (wcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wcnt <= '0;
    else if (win_end)   wcnt <= '0;
    else if (acc_valid) wcnt <= wcnt + 1'b1;
  end
endmodule

// File: rtl/mrm_decide.sv
module mrm_decide #(
  parameter int CNT_W    = 8,
  parameter int LVL_W    = 3,
  parameter int MIN_LVL  = 1,
  parameter int MAX_LVL  = 6,
  parameter int LOW_MARK = -(2 ** (CNT_W - 1))
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_end,
  input  logic signed [CNT_W-1:0] score_nxt,
  input  logic [LVL_W-1:0]        size_level,
  input  logic                    resize_busy,
  output logic                    grow_req,
  output logic                    shrink_req
);
  int  eff_level;
  logic can_grow, can_shrink, want_grow, want_shrink;

  assign eff_level   = mrm_pkg::level_clip(int'(size_level), MIN_LVL, MAX_LVL);
  assign can_grow    = eff_level < MAX_LVL;
  assign can_shrink  = eff_level > MIN_LVL;
  assign want_grow   = int'(score_nxt) > 0;
  assign want_shrink = int'(score_nxt) <= LOW_MARK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grow_req   <= 1'b0;
      shrink_req <= 1'b0;
    end else begin
      grow_req   <= win_end && !resize_busy && want_grow   && can_grow;
      shrink_req <= win_end && !resize_busy && want_shrink && can_shrink;
    end
  end
endmodule

// File: rtl/miss_rate_monitor.sv
module miss_rate_monitor #(
  parameter int CNT_W    = 8,
  parameter int MISS_INC = 19,
  parameter int HIT_DEC  = 1,
  parameter int WINDOW   = 256,
  parameter int LVL_W    = 3,
  parameter int MIN_LVL  = 1,
  parameter int MAX_LVL  = 6,
  parameter int LOW_MARK = -(2 ** (CNT_W - 1))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_miss,
  input  logic [LVL_W-1:0] size_level,
  input  logic             resize_busy,
  output logic             above_thresh,
  output logic             grow_req,
  output logic             shrink_req
);
  logic signed [CNT_W-1:0] score_q;
  logic signed [CNT_W-1:0] score_nxt;
  logic                    win_end;

  mrm_window #(.WINDOW(WINDOW)) u_window (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .win_end(win_end)
  );

  mrm_score #(.CNT_W(CNT_W), .MISS_INC(MISS_INC), .HIT_DEC(HIT_DEC)) u_score (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss),
    .clear(win_end), .score_q(score_q), .score_nxt(score_nxt)
  );

  mrm_decide #(.CNT_W(CNT_W), .LVL_W(LVL_W), .MIN_LVL(MIN_LVL),
               .MAX_LVL(MAX_LVL), .LOW_MARK(LOW_MARK)) u_decide (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .score_nxt(score_nxt),
    .size_level(size_level), .resize_busy(resize_busy),
    .grow_req(grow_req), .shrink_req(shrink_req)
  );

  assign above_thresh = score_q > 0;
endmodule

// File: rtl/mrm_checker.sv
module mrm_checker #(
  parameter int CNT_W    = 8,
  parameter int MISS_INC = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic                    acc_miss,
  input logic                    resize_busy,
  input logic                    grow_req,
  input logic                    shrink_req,
  input logic                    win_end,
  input logic signed [CNT_W-1:0] score_q
);
  localparam int SMAX = (2 ** (CNT_W - 1)) - 1;
  localparam int SMIN = -(2 ** (CNT_W - 1));

  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_miss && !win_end && int'(score_q) > SMIN)
    |=> int'(score_q) == int'($past(score_q)) - 1); // R2
  AST_HIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_miss && !win_end && int'(score_q) == SMIN)
    |=> int'(score_q) == SMIN); // R2
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && !win_end && int'(score_q) <= SMAX - MISS_INC)
    |=> int'(score_q) == int'($past(score_q)) + MISS_INC); // R3
  AST_MISS_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && !win_end && int'(score_q) > SMAX - MISS_INC)
    |=> int'(score_q) == SMAX); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(score_q)); // R5
  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> score_q == 0); // R5
  AST_GROW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    grow_req |-> $past(win_end)); // R6
  AST_SHRINK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_req |-> $past(win_end)); // R7
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resize_busy |=> !grow_req && !shrink_req); // R8
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grow_req, shrink_req})); // R10
endmodule

bind miss_rate_monitor mrm_checker #(.CNT_W(CNT_W), .MISS_INC(MISS_INC)) u_mrm_checker (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss),
  .resize_busy(resize_busy), .grow_req(grow_req), .shrink_req(shrink_req),
  .win_end(win_end), .score_q(score_q)
);

// File: tb/miss_rate_monitor_test.sv
`timescale 1ns/1ps
module miss_rate_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_miss = 1'b0, resize_busy = 1'b0;
  logic [2:0] size_level = 3'd3;
  logic above_thresh, grow_req, shrink_req;

  int n_vec = 0, n_bad = 0, cycles = 0;
  int m_score = 0, m_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  miss_rate_monitor uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss),
    .size_level(size_level), .resize_busy(resize_busy),
    .above_thresh(above_thresh), .grow_req(grow_req), .shrink_req(shrink_req)
  );

  function automatic int b_sat(input int s, input bit miss);
    int r;
    r = miss ? s + 19 : s - 1;
    return (r > 127) ? 127 : ((r < -128) ? -128 : r);
  endfunction

  function automatic int b_lvl(input int l);
    return (l < 1) ? 1 : ((l > 6) ? 6 : l);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit m, input int lvl, input bit busy);
    int nxt, eg, es;
    bit last;
    @(negedge clk);
    acc_valid = v; acc_miss = m; size_level = 3'(lvl); resize_busy = busy;
    nxt  = v ? b_sat(m_score, m) : m_score;
    last = v && (m_cnt == 255);
    eg = (last && nxt > 0 && !busy && b_lvl(lvl) < 6) ? 1 : 0;
    es = (last && nxt <= -128 && !busy && b_lvl(lvl) > 1) ? 1 : 0;
    m_score = last ? 0 : nxt;
    if (v) m_cnt = last ? 0 : m_cnt + 1;
    @(posedge clk); #1;
    check("R4", int'(above_thresh), (m_score > 0) ? 1 : 0);
    check("R6", int'(grow_req), eg);
    check("R7", int'(shrink_req), es);
    check("R10", int'(grow_req & shrink_req), 0);
  endtask

  task automatic fill_window(input bit m, input int lvl, input bit busy);
    while (m_cnt != 255) step(1, m, lvl, busy);
    step(1, m, lvl, busy);
  endtask

  initial begin
    void'($urandom(32'h1d5e));
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(above_thresh), 0);
    check("R1", int'(grow_req | shrink_req), 0);
    @(negedge clk); rst_n = 1'b1;

    // score ladder through the threshold
    step(1, 1, 3, 0);
    for (int i = 0; i < 18; i++) step(1, 0, 3, 0);
    check("R2", int'(above_thresh), 1);
    step(1, 0, 3, 0);
    check("R2", int'(above_thresh), 0);
    // ceiling saturation: 7 misses give 127, not 133
    for (int i = 0; i < 7; i++) step(1, 1, 3, 0);
    for (int i = 0; i < 126; i++) step(1, 0, 3, 0);
    check("R3", int'(above_thresh), 1);
    step(1, 0, 3, 0);
    check("R3", int'(above_thresh), 0);
    fill_window(0, 3, 0);
    // floor saturation: 200 hits stop at -128, 7 misses then give +5
    for (int i = 0; i < 200; i++) step(1, 0, 3, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 3, 0);
    check("R2", int'(above_thresh), 1);
    fill_window(0, 3, 0);

    fill_window(0, 3, 0);
    check("R7", int'(shrink_req), 1);
    fill_window(1, 3, 0);
    check("R6", int'(grow_req), 1);

    fill_window(1, 3, 1);
    check("R8", int'(grow_req), 0);
    step(0, 0, 3, 0);
    check("R8", int'(above_thresh), 0);

    fill_window(1, 7, 0);
    check("R9", int'(grow_req), 0);
    fill_window(0, 0, 0);
    check("R9", int'(shrink_req), 0);
    fill_window(1, 5, 0);
    check("R9", int'(grow_req), 1);

    // window broken up by idle cycles
    for (int i = 0; i < 255; i++) begin
      step(1, 1, 3, 0);
      if (i % 3 == 0) step(0, 1, 3, 0);
    end
    step(0, 1, 3, 0);
    check("R5", int'(grow_req), 0);
    check("R5", int'(above_thresh), 1);
    step(1, 1, 3, 0);
    check("R5", int'(grow_req), 1);
    check("R5", int'(above_thresh), 0);

    // constrained random windows
    for (int w = 0; w < 30; w++) begin
      int thr, lvl;
      bit busy;
      case ($urandom % 4)
        0: thr = 0;
        1: thr = 25;
        2: thr = 100;
        default: thr = 500;
      endcase
      lvl  = $urandom % 8;
      busy = ($urandom % 5) == 0;
      for (int k = 0; k < 300; k++)
        step(($urandom % 4) != 0, ($urandom % 1000) < thr, lvl, busy);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule